// File: doc/BRIEF.md
# Center-Aligned Dual-Slope PWM Timer

This block is a 16-bit up/down timer that produces two symmetric, center-aligned PWM waveforms. Each time the timer clock enable is high, the counter takes one step. It climbs from zero to a turning value, stays on that value for one step, and then falls back to zero. It stays on zero for one step and then climbs again. A 4-bit mode code chooses the turning value. Three modes give fixed values. In the other two modes, a capture-register input or the live compare value of channel A sets the turning value.

Each of the two channels compares the counter against its live compare value. On a match while the counter rises, the channel output goes low. On a match while the counter falls, the output goes high. An inverting mode flips the output, and an off mode holds the pin low. Software writes compare values into a shadow register. The shadow value reaches the live register only at the turning point, so a period never sees a half-applied update.

Four sticky flags report compare matches, arrival at zero and arrival at the turning point. Each flag is cleared by a write-one pulse on its bit of the clear input.

Top module: `pwm_dualslope_timer`

The counter is a two-state machine:
- `DIR_UP` moves to `DIR_DOWN` on the transition *turn at top*.
- `DIR_DOWN` moves to `DIR_UP` on the transition *turn at bottom*.
- In either state, a cycle without an enabled step keeps the state (*hold*).

## Requirements
- R1: The counter runs 0, 1, …, TOP, TOP-1, …, 1 and then repeats, one value per enabled step. Each value, including TOP and 0, lasts one step, so one period is 2·TOP steps.
- R2: The mode code selects TOP:
  - 4'd1 gives 0x00FF.
  - 4'd2 gives 0x01FF.
  - 4'd3 gives 0x03FF.
  - 4'd10 gives the value of `cap_top`.
  - 4'd11 gives the live compare value of channel A.
- R3: Any other mode code freezes the counter. No flag is set and the outputs keep their level.
- R4: The counter and all match and flag events advance only in cycles where `tick` is high.
- R5: The output-mode code is encoded as follows:
  - 2'b10 is true output: the pin goes low after a match while rising and high after a match while falling. With compare value k (0<k<TOP), the pin is high for 2·k steps of each period.
  - 2'b11 is the inverse of true output.
  - 2'b00 and 2'b01 hold the pin low.
- R6: With true output, a compare value of 0 keeps the pin low for the whole period, and a compare value equal to TOP keeps it high. A match at 0 counts as rising, and a match at TOP counts as falling.
- R7: A compare write goes only to the shadow register. The live compare value changes only at the turning point at TOP.
- R8: The overflow flag is set after every turn at bottom.
- R9: A channel's compare flag is set after each enabled step in which the counter equals that channel's live compare value.
- R10: The top flag is set at each turn at top in modes 4'd10 and 4'd11 only.
- R11: Flags stay set until cleared by a pulse on `flag_clr`. The bits are [0] compare A, [1] compare B, [2] overflow and [3] top. If a set and a clear fall in the same cycle, the set wins.
- R12: After reset, the following hold:
  - The counter is 0 and rising.
  - The live and shadow compare values are 0.
  - All flags are 0.
  - The internal level of each channel is low, so a true-output pin reads 0 and an inverting pin reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer clock enable, one counter step per high cycle |
| mode | input | 4 | TOP selection mode code |
| cap_top | input | 16 | Capture register value, used as TOP in mode 10 |
| cmp_a_wr | input | 1 | Write strobe for the channel A shadow compare |
| cmp_a_data | input | 16 | Channel A compare write data |
| cmp_b_wr | input | 1 | Write strobe for the channel B shadow compare |
| cmp_b_data | input | 16 | Channel B compare write data |
| out_mode_a | input | 2 | Channel A output mode |
| out_mode_b | input | 2 | Channel B output mode |
| flag_clr | input | 4 | Write-one-to-clear pulses for the four flags |
| pwm_a | output | 1 | Channel A PWM pin |
| pwm_b | output | 1 | Channel B PWM pin |
| flag_cmp_a | output | 1 | Channel A compare-match flag |
| flag_cmp_b | output | 1 | Channel B compare-match flag |
| flag_ovf | output | 1 | Counter reached bottom |
| flag_top | output | 1 | Counter reached a register-defined TOP |

## Verification
A compare-flag set and a software clear of the same flag can land in the same cycle. The bench provokes this by holding the channel A clear bit high while TOP is 3 and the compare value is 1. This produces two matches every six steps. Over twelve steps the flag must read high exactly four times, once after each match.

A second collision is a compare write that arrives while the counter is rising past the new value. The bench checks that the pin still follows the old value until the next turn at top.

// File: rtl/pwmds_pkg.sv
package pwmds_pkg;

    localparam int NUM_CH = 2;

    typedef enum logic [0:0] {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_state_e;

    typedef enum logic [1:0] {
        OM_OFF  = 2'b00,
        OM_RSVD = 2'b01,
        OM_TRUE = 2'b10,
        OM_INV  = 2'b11
    } out_mode_e;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'b00,
        ACT_CLEAR = 2'b01,
        ACT_SET   = 2'b10
    } edge_act_e;

    localparam logic [3:0] MODE_FIX8   = 4'd1;
    localparam logic [3:0] MODE_FIX9   = 4'd2;
    localparam logic [3:0] MODE_FIX10  = 4'd3;
    localparam logic [3:0] MODE_CAPTOP = 4'd10;
    localparam logic [3:0] MODE_CMPTOP = 4'd11;

endpackage

// File: rtl/pwmds_top_sel.sv
module pwmds_top_sel
    import pwmds_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [3:0]       mode,
    input  logic [CNT_W-1:0] cap_top,
    input  logic [CNT_W-1:0] live_cmp_a,
    output logic [CNT_W-1:0] top_val,
    output logic             mode_ok,
    output logic             reg_top
);

    localparam logic [CNT_W-1:0] TOP_8B  = CNT_W'((1 << 8) - 1);
    localparam logic [CNT_W-1:0] TOP_9B  = CNT_W'((1 << 9) - 1);
    localparam logic [CNT_W-1:0] TOP_10B = CNT_W'((1 << 10) - 1);

    always_comb begin
        top_val = '0;
        mode_ok = 1'b1;
        reg_top = 1'b0;
        unique case (mode)
            MODE_FIX8:   top_val = TOP_8B;
            MODE_FIX9:   top_val = TOP_9B;
            MODE_FIX10:  top_val = TOP_10B;
            MODE_CAPTOP: begin
                top_val = cap_top;
                reg_top = 1'b1;
            end
            MODE_CMPTOP: begin
                top_val = live_cmp_a;
                reg_top = 1'b1;
            end
            default:     mode_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwmds_counter.sv
module pwmds_counter
    import pwmds_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic [CNT_W-1:0] top_val,
    output logic [CNT_W-1:0] cnt,
    output dir_state_e       dir,
    output logic             top_evt,
    output logic             bot_evt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    dir_state_e       dir_q, dir_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= DIR_UP;
            cnt_q <= '0;
        end else begin
            dir_q <= dir_d;
            cnt_q <= cnt_d;
        end
    end

    // next state and event outputs
    always_comb begin
        dir_d   = dir_q;
        cnt_d   = cnt_q;
        top_evt = 1'b0;
        bot_evt = 1'b0;
        unique case (dir_q)
            DIR_UP: begin
                if (advance && (cnt_q >= top_val) && (cnt_q != '0)) begin
                    top_evt = 1'b1;          // turn at top
                    dir_d   = DIR_DOWN;
                    cnt_d   = cnt_q - ONE;
                end else if (advance) begin
                    cnt_d   = cnt_q + ONE;
                end
            end
            DIR_DOWN: begin
                if (advance && (cnt_q == '0)) begin
                    bot_evt = 1'b1;          // turn at bottom
                    dir_d   = DIR_UP;
                    cnt_d   = ONE;
                end else if (advance) begin
                    cnt_d   = cnt_q - ONE;
                end
            end
            default: dir_d = DIR_UP;
        endcase
    end

    assign cnt = cnt_q;
    assign dir = dir_q;

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> ($stable(cnt_q) && $stable(dir_q)));

    p_top_turn_r1: assert property (@(posedge clk) disable iff (!rst_n)
        top_evt |=> (dir_q == DIR_DOWN && cnt_q == $past(cnt_q) - ONE));

    p_bottom_turn_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bot_evt |=> (dir_q == DIR_UP && cnt_q == ONE));

endmodule

// File: rtl/pwmds_channel.sv
module pwmds_channel
    import pwmds_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             load,
    input  logic             advance,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] top_val,
    input  dir_state_e       dir,
    input  logic [1:0]       omode,
    output logic [CNT_W-1:0] live_cmp,
    output logic             match,
    output logic             pin
);

    logic [CNT_W-1:0] shadow_q, live_q;
    logic             level_q;
    edge_act_e        act;

    // shadow and live compare registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            live_q   <= '0;
        end else begin
            if (wr_en) shadow_q <= wr_data;
            if (load)  live_q   <= shadow_q;
        end
    end

    // match direction: 0 counts as rising, TOP as falling
    always_comb begin
        match = advance && (cnt == live_q);
        act   = ACT_NONE;
        if (match) begin
            if (cnt == '0)                act = ACT_CLEAR;
            else if (cnt == top_val)      act = ACT_SET;
            else if (dir == DIR_UP)       act = ACT_CLEAR;
            else                          act = ACT_SET;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            unique case (act)
                ACT_CLEAR: level_q <= 1'b0;
                ACT_SET:   level_q <= 1'b1;
                default:   level_q <= level_q;
            endcase
        end
    end

    always_comb begin
        unique case (out_mode_e'(omode))
            OM_TRUE: pin = level_q;
            OM_INV:  pin = ~level_q;
            default: pin = 1'b0;
        endcase
    end

    assign live_cmp = live_q;

    p_live_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(live_q));

    p_live_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (live_q == $past(shadow_q)));

    p_up_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (match && dir == DIR_UP && cnt != top_val) |=> !level_q);

    p_down_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (match && dir == DIR_DOWN && cnt != '0) |=> level_q);

endmodule

// File: rtl/pwm_dualslope_timer.sv
module pwm_dualslope_timer
    import pwmds_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [3:0]       mode,
    input  logic [CNT_W-1:0] cap_top,
    input  logic             cmp_a_wr,
    input  logic [CNT_W-1:0] cmp_a_data,
    input  logic             cmp_b_wr,
    input  logic [CNT_W-1:0] cmp_b_data,
    input  logic [1:0]       out_mode_a,
    input  logic [1:0]       out_mode_b,
    input  logic [3:0]       flag_clr,
    output logic             pwm_a,
    output logic             pwm_b,
    output logic             flag_cmp_a,
    output logic             flag_cmp_b,
    output logic             flag_ovf,
    output logic             flag_top
);

    localparam int CLR_OVF = NUM_CH;
    localparam int CLR_TOP = NUM_CH + 1;

    logic [CNT_W-1:0] top_val, cnt_w;
    logic             mode_ok, reg_top, adv, top_evt, bot_evt;
    dir_state_e       dir_w;

    logic [NUM_CH-1:0]            wr_v, match_v, pin_v;
    logic [NUM_CH-1:0][CNT_W-1:0] data_v, live_v;
    logic [NUM_CH-1:0][1:0]       om_v;
    logic [NUM_CH-1:0]            flag_cmp_q;
    logic                         flag_ovf_q, flag_top_q;

    assign wr_v   = {cmp_b_wr, cmp_a_wr};
    assign data_v = {cmp_b_data, cmp_a_data};
    assign om_v   = {out_mode_b, out_mode_a};
    assign adv    = tick && mode_ok;

    pwmds_top_sel #(.CNT_W(CNT_W)) u_top_sel (
        .mode       (mode),
        .cap_top    (cap_top),
        .live_cmp_a (live_v[0]),
        .top_val    (top_val),
        .mode_ok    (mode_ok),
        .reg_top    (reg_top)
    );

    pwmds_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (adv),
        .top_val (top_val),
        .cnt     (cnt_w),
        .dir     (dir_w),
        .top_evt (top_evt),
        .bot_evt (bot_evt)
    );

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        pwmds_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_v[gi]),
            .wr_data  (data_v[gi]),
            .load     (top_evt),
            .advance  (adv),
            .cnt      (cnt_w),
            .top_val  (top_val),
            .dir      (dir_w),
            .omode    (om_v[gi]),
            .live_cmp (live_v[gi]),
            .match    (match_v[gi]),
            .pin      (pin_v[gi])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_cmp_q[gi] <= 1'b0;
            else        flag_cmp_q[gi] <= (flag_cmp_q[gi] && !flag_clr[gi]) || match_v[gi];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_ovf_q <= 1'b0;
            flag_top_q <= 1'b0;
        end else begin
            flag_ovf_q <= (flag_ovf_q && !flag_clr[CLR_OVF]) || bot_evt;
            flag_top_q <= (flag_top_q && !flag_clr[CLR_TOP]) || (top_evt && reg_top);
        end
    end

    assign pwm_a      = pin_v[0];
    assign pwm_b      = pin_v[1];
    assign flag_cmp_a = flag_cmp_q[0];
    assign flag_cmp_b = flag_cmp_q[1];
    assign flag_ovf   = flag_ovf_q;
    assign flag_top   = flag_top_q;

    p_ovf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bot_evt |=> flag_ovf);

    p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ovf && !flag_clr[CLR_OVF]) |=> flag_ovf);

    p_cmp_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        match_v[0] |=> flag_cmp_a);

    p_freeze_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ok |=> $stable(cnt_w));

    p_top_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_top && !flag_top && !flag_clr[CLR_TOP]) |=> !flag_top);

endmodule

// File: tb/pwm_dualslope_timer_tb_top.sv
module pwm_dualslope_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [3:0]  mode = 4'd10;
    logic [15:0] cap_top = 16'd3;
    logic        cmp_a_wr = 1'b0, cmp_b_wr = 1'b0;
    logic [15:0] cmp_a_data = '0, cmp_b_data = '0;
    logic [1:0]  out_mode_a = 2'b10, out_mode_b = 2'b11;
    logic [3:0]  flag_clr = 4'b0000;
    logic        pwm_a, pwm_b, flag_cmp_a, flag_cmp_b, flag_ovf, flag_top;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    pwm_dualslope_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .cap_top(cap_top),
        .cmp_a_wr(cmp_a_wr), .cmp_a_data(cmp_a_data),
        .cmp_b_wr(cmp_b_wr), .cmp_b_data(cmp_b_data),
        .out_mode_a(out_mode_a), .out_mode_b(out_mode_b), .flag_clr(flag_clr),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .flag_cmp_a(flag_cmp_a), .flag_cmp_b(flag_cmp_b),
        .flag_ovf(flag_ovf), .flag_top(flag_top)
    );

    typedef struct packed {
        logic [3:0]  md;
        logic [15:0] cap;
        logic [15:0] ca;
        logic [15:0] cb;
        logic [1:0]  oa;
        logic [1:0]  ob;
        int          per;
        int          ha;
        int          hb;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{4'd1,  16'd0,  16'd100, 16'd200, 2'b10, 2'b11, 510,  200,  110},
        '{4'd10, 16'd3,  16'd1,   16'd0,   2'b10, 2'b10, 6,    2,    0},
        '{4'd10, 16'd10, 16'd10,  16'd5,   2'b10, 2'b11, 20,   20,   10},
        '{4'd2,  16'd0,  16'd0,   16'd300, 2'b11, 2'b00, 1022, 1022, 0},
        '{4'd3,  16'd0,  16'd512, 16'd1,   2'b10, 2'b11, 2046, 1024, 2044},
        '{4'd11, 16'd0,  16'd20,  16'd7,   2'b10, 2'b10, 40,   40,   14}
    };

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    task automatic write_cmp(input logic [15:0] a, input logic [15:0] b);
        cmp_a_wr = 1'b1; cmp_a_data = a;
        cmp_b_wr = 1'b1; cmp_b_data = b;
        step();
        cmp_a_wr = 1'b0; cmp_b_wr = 1'b0;
    endtask

    task automatic sync_bottom();
        flag_clr = 4'b0100;
        step();
        flag_clr = 4'b0000;
        while (!flag_ovf) step();
    endtask

    task automatic run_period(output int cyc, output int ha, output int hb);
        sync_bottom();
        cyc = 0; ha = 0; hb = 0;
        flag_clr = 4'b0100;
        do begin
            ha += int'(pwm_a);
            hb += int'(pwm_b);
            cyc++;
            step();
            flag_clr = 4'b0000;
        end while (!flag_ovf);
    endtask

    initial begin
        int cyc, ha, hb, ones;
        logic hold_a;
        step(3);
        // R12 reset state
        check(pwm_a == 1'b0, "R12 true pin after reset", int'(pwm_a), 0);
        check(pwm_b == 1'b1, "R12 inverting pin after reset", int'(pwm_b), 1);
        check({flag_cmp_a, flag_cmp_b, flag_ovf, flag_top} == 4'b0000, "R12 flags after reset",
              int'({flag_cmp_a, flag_cmp_b, flag_ovf, flag_top}), 0);
        rst_n = 1'b1;
        step(50);
        // R4 no tick: counter at 0 with live compare 0 would match if stepping
        check({flag_cmp_a, flag_ovf, flag_top} == 3'b000, "R4 no events without tick",
              int'({flag_cmp_a, flag_ovf, flag_top}), 0);
        tick = 1'b1;

        // table walk: R1 R2 R5 R6
        for (int v = 0; v < NV; v++) begin
            mode = VECS[v].md; cap_top = VECS[v].cap;
            out_mode_a = VECS[v].oa; out_mode_b = VECS[v].ob;
            write_cmp(VECS[v].ca, VECS[v].cb);
            run_period(cyc, ha, hb);
            run_period(cyc, ha, hb);
            run_period(cyc, ha, hb);
            check(cyc == VECS[v].per, $sformatf("R1/R2 period vec%0d", v), cyc, VECS[v].per);
            check(ha == VECS[v].ha, $sformatf("R5/R6 pwm_a high vec%0d", v), ha, VECS[v].ha);
            check(hb == VECS[v].hb, $sformatf("R5/R6 pwm_b high vec%0d", v), hb, VECS[v].hb);
        end

        // R7 shadow compare: write 10 while rising, live stays 50 until TOP
        mode = 4'd10; cap_top = 16'd100; out_mode_a = 2'b10; out_mode_b = 2'b10;
        write_cmp(16'd50, 16'd50);
        run_period(cyc, ha, hb);
        run_period(cyc, ha, hb);
        sync_bottom();
        cmp_a_wr = 1'b1; cmp_a_data = 16'd10;
        step();
        cmp_a_wr = 1'b0;
        step(28);
        check(pwm_a == 1'b1, "R7 write not live before TOP", int'(pwm_a), 1);
        run_period(cyc, ha, hb);
        run_period(cyc, ha, hb);
        check(ha == 20, "R7 new compare live after TOP", ha, 20);

        // R11 set wins over clear; R9 compare flag
        cap_top = 16'd3;
        write_cmp(16'd1, 16'd2);
        run_period(cyc, ha, hb);
        run_period(cyc, ha, hb);
        flag_clr = 4'b0001;
        step();
        ones = 0;
        for (int i = 0; i < 12; i++) begin
            ones += int'(flag_cmp_a);
            step();
        end
        flag_clr = 4'b0000;
        check(ones == 4, "R11 set beats concurrent clear", ones, 4);
        step(20);
        check(flag_cmp_a == 1'b1, "R11 flag sticky", int'(flag_cmp_a), 1);
        check(flag_cmp_b == 1'b1, "R9 compare B flag", int'(flag_cmp_b), 1);

        // R10 top flag in register mode, not in fixed mode
        flag_clr = 4'b1000; step(); flag_clr = 4'b0000;
        step(10);
        check(flag_top == 1'b1, "R10 top flag in mode 10", int'(flag_top), 1);
        mode = 4'd1;
        run_period(cyc, ha, hb);
        flag_clr = 4'b1100; step(); flag_clr = 4'b0000;
        step(520);
        check(flag_top == 1'b0, "R10 no top flag in mode 1", int'(flag_top), 0);
        check(flag_ovf == 1'b1, "R8 overflow flag at bottom", int'(flag_ovf), 1);

        // R3 unsupported mode freezes
        mode = 4'd0;
        step();
        flag_clr = 4'b1111; step(); flag_clr = 4'b0000;
        hold_a = pwm_a;
        step(600);
        check({flag_cmp_a, flag_cmp_b, flag_ovf, flag_top} == 4'b0000, "R3 no flags when frozen",
              int'({flag_cmp_a, flag_cmp_b, flag_ovf, flag_top}), 0);
        check(pwm_a == hold_a, "R3 pin holds when frozen", int'(pwm_a), int'(hold_a));

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #1ms;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule